// File: doc/BRIEF.md
# Cascaded Rotating-Priority Interrupt Resolver

This block resolves interrupt requests for a pair of eight-line controllers, a master and a slave, linked through master line 2. In each controller the unmasked pending lines are ranked against a rotatable priority base. The best candidate is compared with the highest-ranked line already in service, and an interrupt is raised only when the candidate outranks it. The slave's own interrupt is fed in as the request on master line 2, so nesting across the two controllers works the same way as nesting inside one.

When the processor acknowledges, the block returns a vector number in the same cycle: the upper bits come from a per-controller base and the low three bits are the line. On the clock edge that ends the acknowledge cycle the block updates the in-service state. Auto end-of-interrupt, rotate-on-auto-EOI and a special fully nested mode for the master are controlled by mode inputs. The host command decoder sits outside this block and drives specific end-of-interrupt clears and loads of the priority base through plain strobes.

Top module: `cascade_prio_resolver`

## Requirements
- R1: The candidate set of a controller is its pending bits AND NOT its mask bits. `pend_i`/`mask_i` bits 7:0 belong to the master and bits 15:8 to the slave (bit 8+k is slave line k). A masked line never causes `irq_o`.
- R2: With base offset k, the ranking from highest to lowest is line k, k+1, ..., k+7, all taken mod 8. With offset 0, line 0 is the highest.
- R3: `irq_o` is high only when the best candidate ranks strictly above the best in-service line. A candidate of equal rank does not interrupt. An empty in-service set always loses.
- R4: During an acknowledge, `vector_o` equals the 5-bit base of the servicing controller in bits 7:3 and the line number in bits 2:0.
- R5: An acknowledge with auto-EOI off sets the in-service bit of the acknowledged line on the next edge. With auto-EOI on, the in-service state is unchanged. If rotate-on-auto-EOI is also set, the offset becomes (line+1) mod 8.
- R6: An acknowledge while `irq_o` is low gives `vector_o` = {master base, 3'd7}, raises `spurious_o` and changes no state.
- R7: A slave interrupt acts as a request on master line 2. Acknowledging master line 2 also acknowledges the slave line and returns {slave base, slave line}. If the slave has nothing, the result is {slave base, 3'd7} with `spurious_o` high, and the master's in-service bit 2 is still set.
- R8: When `sfnm_i` is set, master in-service bit 2 is left out of the master's in-service rank.
- R9: `eoi_i[c]` clears in-service bit `eoi_line_i` of controller c (0 is master, 1 is slave). `off_ld_i[c]` loads `off_val_i` into that controller's offset. On a collision, an acknowledge set wins over a clear, and a load wins over an auto-EOI rotation.
- R10: After reset both in-service registers and both offsets are zero and `irq_o` is low. `irq_o` follows a state change in the cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | 16 | Pending requests, slave in 15:8, master in 7:0 |
| mask_i | input | 16 | Mask bits, same layout |
| base0_i | input | 5 | Master vector base (vector bits 7:3) |
| base1_i | input | 5 | Slave vector base |
| aeoi_i | input | 2 | Auto-EOI enable per controller |
| rot_aeoi_i | input | 2 | Rotate-on-auto-EOI per controller |
| sfnm_i | input | 1 | Special fully nested mode on the master |
| off_ld_i | input | 2 | Offset load strobe per controller |
| off_val_i | input | 3 | Offset value to load |
| eoi_i | input | 2 | Specific end-of-interrupt strobe per controller |
| eoi_line_i | input | 3 | Line cleared by `eoi_i` |
| ack_i | input | 1 | Acknowledge strobe, one cycle |
| irq_o | output | 1 | Interrupt request to the processor |
| vector_o | output | 8 | Vector number, valid while `ack_i` is high |
| spurious_o | output | 1 | Acknowledge found no real line |
| m_isr_o | output | 8 | Master in-service register |
| s_isr_o | output | 8 | Slave in-service register |
| m_off_o | output | 3 | Master priority offset |
| s_off_o | output | 3 | Slave priority offset |

## Verification
The main function is tried in four ways. A single line then a higher line tests nesting against the strict rank rule. Two lines under offsets 4 and 0 show that the winner flips with rotation, which a fixed order could not produce. Auto-EOI sequences show in-service state untouched while the offset walks. Cascade patterns cover a slave hit, a slave spurious result, and the same nested slave request with and without special fully nested mode, which is the only difference between a held and a released `irq_o`.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;
    localparam int LINES   = 8;
    localparam int LW      = $clog2(LINES);
    localparam int VEC_W   = 8;
    localparam int BASE_W  = VEC_W - LW;
    localparam int CASC_LN = 2;

    typedef struct packed {
        logic [LINES-1:0] isr;
        logic [LW-1:0]    off;
    } ctrl_state_t;
endpackage

// File: rtl/prio_scan.sv
module prio_scan #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req_i,
    input  logic [W-1:0] off_i,
    output logic         hit_o,
    output logic [W-1:0] prio_o
);
    // rank p looks at line (p + off) mod N; N must be a power of two
    always_comb begin
        hit_o  = 1'b0;
        prio_o = '0;
        for (int p = N - 1; p >= 0; p--) begin
            if (req_i[off_i + W'(p)]) begin
                hit_o  = 1'b1;
                prio_o = W'(p);
            end
        end
    end
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
    import prio_res_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pend_i,
    input  logic [LINES-1:0] mask_i,
    input  logic             aeoi_i,
    input  logic             rot_aeoi_i,
    input  logic             sfnm_i,
    input  logic             off_ld_i,
    input  logic [LW-1:0]    off_val_i,
    input  logic             eoi_i,
    input  logic [LW-1:0]    eoi_line_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic [LW-1:0]    line_o,
    output logic [LINES-1:0] isr_o,
    output logic [LW-1:0]    off_o
);
    ctrl_state_t st_d, st_q;

    logic [LINES-1:0] cand_vec, isr_view;
    logic             cand_hit, isr_hit;
    logic [LW-1:0]    cand_prio, isr_prio;

    assign cand_vec = pend_i & ~mask_i;

    generate
        if (IS_MASTER) begin : g_master_view
            always_comb begin
                isr_view = st_q.isr;
                if (sfnm_i) isr_view[CASC_LN] = 1'b0;
            end
        end else begin : g_slave_view
            logic unused_sfnm;
            assign unused_sfnm = sfnm_i;
            assign isr_view    = st_q.isr;
        end
    endgenerate

    prio_scan #(.N(LINES)) cand_scan_i (
        .req_i (cand_vec),
        .off_i (st_q.off),
        .hit_o (cand_hit),
        .prio_o(cand_prio)
    );

    prio_scan #(.N(LINES)) isr_scan_i (
        .req_i (isr_view),
        .off_i (st_q.off),
        .hit_o (isr_hit),
        .prio_o(isr_prio)
    );

    assign irq_o  = cand_hit && (!isr_hit || (cand_prio < isr_prio));
    assign line_o = cand_prio + st_q.off;
    assign isr_o  = st_q.isr;
    assign off_o  = st_q.off;

    always_comb begin
        st_d = st_q;
        if (eoi_i) st_d.isr[eoi_line_i] = 1'b0;
        if (ack_i && irq_o) begin
            if (aeoi_i) begin
                if (rot_aeoi_i) st_d.off = line_o + LW'(1);
            end else begin
                st_d.isr[line_o] = 1'b1;
            end
        end
        if (off_ld_i) st_d.off = off_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cascade_prio_resolver.sv
module cascade_prio_resolver
    import prio_res_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*LINES-1:0]   pend_i,
    input  logic [2*LINES-1:0]   mask_i,
    input  logic [BASE_W-1:0]    base0_i,
    input  logic [BASE_W-1:0]    base1_i,
    input  logic [1:0]           aeoi_i,
    input  logic [1:0]           rot_aeoi_i,
    input  logic                 sfnm_i,
    input  logic [1:0]           off_ld_i,
    input  logic [LW-1:0]        off_val_i,
    input  logic [1:0]           eoi_i,
    input  logic [LW-1:0]        eoi_line_i,
    input  logic                 ack_i,
    output logic                 irq_o,
    output logic [VEC_W-1:0]     vector_o,
    output logic                 spurious_o,
    output logic [LINES-1:0]     m_isr_o,
    output logic [LINES-1:0]     s_isr_o,
    output logic [LW-1:0]        m_off_o,
    output logic [LW-1:0]        s_off_o
);
    logic             s_irq, m_irq, s_ack;
    logic [LW-1:0]    s_line, m_line;
    logic [LINES-1:0] m_pend;

    always_comb begin
        m_pend          = pend_i[LINES-1:0];
        m_pend[CASC_LN] = pend_i[CASC_LN] | s_irq;
    end

    assign s_ack = ack_i && m_irq && (m_line == LW'(CASC_LN));

    irq_ctrl_unit #(.IS_MASTER(1'b1)) master_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (m_pend),
        .mask_i    (mask_i[LINES-1:0]),
        .aeoi_i    (aeoi_i[0]),
        .rot_aeoi_i(rot_aeoi_i[0]),
        .sfnm_i    (sfnm_i),
        .off_ld_i  (off_ld_i[0]),
        .off_val_i (off_val_i),
        .eoi_i     (eoi_i[0]),
        .eoi_line_i(eoi_line_i),
        .ack_i     (ack_i),
        .irq_o     (m_irq),
        .line_o    (m_line),
        .isr_o     (m_isr_o),
        .off_o     (m_off_o)
    );

    irq_ctrl_unit #(.IS_MASTER(1'b0)) slave_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend_i[2*LINES-1:LINES]),
        .mask_i    (mask_i[2*LINES-1:LINES]),
        .aeoi_i    (aeoi_i[1]),
        .rot_aeoi_i(rot_aeoi_i[1]),
        .sfnm_i    (1'b0),
        .off_ld_i  (off_ld_i[1]),
        .off_val_i (off_val_i),
        .eoi_i     (eoi_i[1]),
        .eoi_line_i(eoi_line_i),
        .ack_i     (s_ack),
        .irq_o     (s_irq),
        .line_o    (s_line),
        .isr_o     (s_isr_o),
        .off_o     (s_off_o)
    );

    assign irq_o = m_irq;

    always_comb begin
        spurious_o = 1'b0;
        if (!m_irq) begin
            vector_o   = {base0_i, {LW{1'b1}}};
            spurious_o = 1'b1;
        end else if (m_line == LW'(CASC_LN)) begin
            if (s_irq) begin
                vector_o = {base1_i, s_line};
            end else begin
                vector_o   = {base1_i, {LW{1'b1}}};
                spurious_o = 1'b1;
            end
        end else begin
            vector_o = {base0_i, m_line};
        end
    end
endmodule

// File: rtl/cascade_prio_resolver_chk.sv
module cascade_prio_resolver_chk
    import prio_res_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [2*LINES-1:0]   pend_i,
    input logic [2*LINES-1:0]   mask_i,
    input logic [BASE_W-1:0]    base0_i,
    input logic [BASE_W-1:0]    base1_i,
    input logic [1:0]           aeoi_i,
    input logic [1:0]           off_ld_i,
    input logic [1:0]           eoi_i,
    input logic                 ack_i,
    input logic                 irq_o,
    input logic [VEC_W-1:0]     vector_o,
    input logic                 spurious_o,
    input logic [LINES-1:0]     m_isr_o,
    input logic [LINES-1:0]     s_isr_o,
    input logic [LW-1:0]        m_off_o,
    input logic [LW-1:0]        s_off_o
);
    a_r1_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((pend_i[LINES-1:0] & ~mask_i[LINES-1:0]) != 0) ||
                  (!mask_i[CASC_LN] && ((pend_i[2*LINES-1:LINES] & ~mask_i[2*LINES-1:LINES]) != 0)));

    a_r4_vec_base: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |-> (vector_o[VEC_W-1:LW] == base0_i) || (vector_o[VEC_W-1:LW] == base1_i));

    a_r5_isr_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !aeoi_i[0] && !eoi_i[0]) |=> (m_isr_o != '0));

    a_r5_aeoi_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && aeoi_i == 2'b11 && eoi_i == 2'b00) |=> ($stable(m_isr_o) && $stable(s_isr_o)));

    a_r6_spur_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_o) |-> spurious_o);

    a_r6_spur_line: assert property (@(posedge clk) disable iff (!rst_n)
        spurious_o |-> (vector_o[LW-1:0] == {LW{1'b1}}));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && eoi_i == 2'b00 && off_ld_i == 2'b00) |=>
            ($stable(m_isr_o) && $stable(s_isr_o) && $stable(m_off_o) && $stable(s_off_o)));
endmodule

bind cascade_prio_resolver cascade_prio_resolver_chk chk_i (.*);

// File: tb/cascade_prio_resolver_tb_top.sv
module cascade_prio_resolver_tb_top;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic [15:0] pend_i = '0, mask_i = '0;
    logic [4:0]  base0_i = 5'h04, base1_i = 5'h0E;
    logic [1:0]  aeoi_i = '0, rot_aeoi_i = '0, off_ld_i = '0, eoi_i = '0;
    logic        sfnm_i = 1'b0, ack_i = 1'b0;
    logic [2:0]  off_val_i = '0, eoi_line_i = '0;
    logic        irq_o, spurious_o;
    logic [7:0]  vector_o, m_isr_o, s_isr_o;
    logic [2:0]  m_off_o, s_off_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    cascade_prio_resolver dut_i (.*);

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic ack(logic spur, logic [7:0] vec, string tag);
        ack_i = 1'b1;
        exp_q.push_back({spur, vec});
        tag_q.push_back(tag);
        step();
        ack_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic eoi(int c, logic [2:0] ln);
        eoi_i[c] = 1'b1; eoi_line_i = ln;
        step();
        eoi_i = '0;
        @(negedge clk);
    endtask

    task automatic load_off(int c, logic [2:0] v);
        off_ld_i[c] = 1'b1; off_val_i = v;
        step();
        off_ld_i = '0;
        @(negedge clk);
    endtask

    // monitor: compares every acknowledge result against the scoreboard
    always @(negedge clk) begin
        if (ack_i && exp_q.size() > 0) begin
            logic [8:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " vector"}, vector_o, e[7:0]);
            check({t, " spurious"}, spurious_o, e[8]);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hang expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset irq", irq_o, 0);
        check("R10 reset isr", {m_isr_o, s_isr_o}, 0);
        check("R10 reset off", {m_off_o, s_off_o}, 0);

        // nesting and strict rank
        pend_i = 16'h0020; @(negedge clk);
        check("R3 single line irq", irq_o, 1);
        ack(1'b0, 8'h25, "R4 line5");
        check("R5 isr set", m_isr_o, 8'h20);
        check("R3 equal rank no irq", irq_o, 0);
        pend_i = 16'h0028; @(negedge clk);
        check("R3 higher line irq", irq_o, 1);
        ack(1'b0, 8'h23, "R4 line3");
        check("R5 nested isr", m_isr_o, 8'h28);
        eoi(0, 3'd3);
        check("R9 eoi clear", m_isr_o, 8'h20);
        eoi(0, 3'd5);
        pend_i = '0;

        // masking and spurious
        pend_i = 16'h0002; mask_i = 16'h0002; @(negedge clk);
        check("R1 masked no irq", irq_o, 0);
        ack(1'b1, 8'h27, "R6 spurious");
        check("R6 no state change", m_isr_o, 0);
        mask_i = '0; pend_i = '0;

        // rotation
        load_off(0, 3'd4);
        check("R9 offset load", m_off_o, 4);
        pend_i = 16'h0042; @(negedge clk);
        ack(1'b0, 8'h26, "R2 offset4 picks line6");
        eoi(0, 3'd6);
        load_off(0, 3'd0);
        ack(1'b0, 8'h21, "R2 offset0 picks line1");
        eoi(0, 3'd1);

        // auto-EOI with rotation
        aeoi_i = 2'b11; rot_aeoi_i = 2'b01;
        pend_i = 16'h0008; @(negedge clk);
        ack(1'b0, 8'h23, "R5 aeoi line3");
        check("R5 aeoi isr clear", m_isr_o, 0);
        check("R5 aeoi rotate", m_off_o, 4);
        pend_i = 16'h0028; @(negedge clk);
        ack(1'b0, 8'h25, "R5 rotated pick line5");
        check("R5 second rotate", m_off_o, 6);
        aeoi_i = '0; rot_aeoi_i = '0; pend_i = '0;
        load_off(0, 3'd0);

        // cascade
        pend_i = 16'h1000; @(negedge clk);
        check("R7 slave raises irq", irq_o, 1);
        ack(1'b0, 8'h74, "R7 slave line4");
        check("R7 master isr2", m_isr_o, 8'h04);
        check("R7 slave isr4", s_isr_o, 8'h10);
        pend_i = 16'h1200; @(negedge clk);
        check("R8 no sfnm blocks", irq_o, 0);
        sfnm_i = 1'b1; @(negedge clk);
        check("R8 sfnm passes", irq_o, 1);
        ack(1'b0, 8'h71, "R8 nested slave line1");
        check("R8 slave isr", s_isr_o, 8'h12);
        sfnm_i = 1'b0; pend_i = '0;
        eoi(0, 3'd2); eoi(1, 3'd1); eoi(1, 3'd4);
        check("R9 slave eoi", s_isr_o, 0);

        // slave spurious through master line 2
        pend_i = 16'h0004; @(negedge clk);
        ack(1'b1, 8'h77, "R7 slave spurious");
        check("R7 spurious sets master isr2", m_isr_o, 8'h04);
        check("R7 spurious slave untouched", s_isr_o, 0);
        pend_i = '0;

        // collision: ack set wins over clear of the same line
        pend_i = 16'h0001; @(negedge clk);
        eoi_i[0] = 1'b1; eoi_line_i = 3'd0;
        ack(1'b0, 8'h20, "R9 collision ack");
        eoi_i = '0;
        check("R9 set beats clear", m_isr_o, 8'h05);

        check("scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule